// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one per clock, the column addresses a synchronous DRAM visits during a single read or write burst. A one-cycle start strobe captures the starting column, a 3-bit burst-length code and an ordering bit. From the following cycle the block presents the column for each beat with a valid flag. It marks the final beat of fixed-length bursts with a last flag.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size: only the low column bits move, and the upper bits keep the starting value. The low bits follow either a wrapping increment (sequential) or the start offset XOR a beat count (interleaved). A full-page burst increments through the whole row, wraps past the top column, and runs until a terminate strobe or a new start cuts it off. The block issues no commands, moves no data and applies no read latency.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0 until a start is accepted.
- R2: A start accepted at one rising edge makes the first beat appear from that edge: `valid_o`=1 and `col_o` equal to the captured `col_i`.
- R3: `blen_i` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. The reserved codes 4, 5 and 6 behave as 1 beat.
- R4: In sequential order with a fixed length L, beat k shows offset (s+k) mod L, where s is the starting column mod L. The column bits above the block do not change.
- R5: In interleaved order (`ilv_i`=1) with a fixed length L, beat k shows offset s XOR k, with the same fixed upper bits.
- R6: A full-page burst shows (start+k) mod 2^COL_W for every beat k and never ends on its own. `ilv_i` has no effect in full-page mode, and `last_o` is never 1 during it.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst. `valid_o` drops on the following cycle unless a new start is accepted at that edge.
- R8: `term_i` high during a valid beat makes that beat the final one, and `valid_o` is 0 on the next cycle. `term_i` while idle has no effect.
- R9: A start accepted during a burst abandons that burst and begins the new one from its first beat. When start and terminate fall in the same cycle, the start wins.
- R10: The beats of a burst appear on consecutive cycles, one per rising edge, with `valid_o` held high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a new burst this cycle |
| col_i | input | COL_W | Starting column, captured with start |
| blen_i | input | 3 | Burst length code, captured with start |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Cut the running burst after the current beat |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Current beat is part of a burst |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
Start can land in the same cycle as a terminate, or in the same cycle as the last beat of a fixed burst. In both cases the new burst must take over without a gap. The bench drives start and terminate together in the middle of an 8-beat burst and expects the new first column on the next cycle. It also restarts on the last beat of a 2-beat burst and expects the new burst's first beat right after, with `valid_o` never dropping. Assertions in the control logic check that a start is always followed by a valid beat, and that a terminate or last beat without a start is followed by idle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } blen_code_e;

  // log2 of the beat count for fixed lengths; reserved codes act as one beat
  function automatic int unsigned blen_log2(input logic [2:0] code);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 2;
      BL_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction

  function automatic logic blen_is_page(input logic [2:0] code);
    return code == BL_PAGE;
  endfunction

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] wrap_mask_o,
  output logic             page_o,
  output logic             ilv_eff_o
);

  int unsigned lg;

  always_comb begin
    lg     = blen_log2(blen_i);
    page_o = blen_is_page(blen_i);
    for (int i = 0; i < COL_W; i++) begin
      wrap_mask_o[i] = page_o || (i < lg);
    end
    // full page is sequential only
    ilv_eff_o = ilv_i && !page_o;
  end

endmodule

// File: rtl/colgen_beat_ctl.sv
module colgen_beat_ctl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_d,
  input  logic             page_d,
  input  logic             ilv_d,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             page_o,
  output logic             last_o
);

  logic             active_q, ilv_q, page_q;
  logic [COL_W-1:0] cnt_q, base_q, mask_q;

  // named events for the checks
  logic ev_final_beat, ev_cut, ev_restart;

  assign ev_final_beat = active_q && !page_q && (cnt_q == mask_q);
  assign ev_cut        = active_q && term_i && !start_i;
  assign ev_restart    = active_q && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= col_i;
      mask_q   <= mask_d;
      ilv_q    <= ilv_d;
      page_q   <= page_d;
    end else if (active_q) begin
      if (term_i || ev_final_beat) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign page_o   = page_q;
  assign last_o   = ev_final_beat;

  // R9: an accepted start always yields a beat on the next cycle
  p_start_gives_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_q);

  // R8: a cut without a start leaves the block idle
  p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cut |=> !active_q);

  // R7: the final beat without a restart is followed by idle
  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_final_beat && !start_i) |=> !active_q);

  // R6: full page never flags a final beat
  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && page_q) |-> !last_o);

  // R10: a running beat that is neither cut nor final advances by one
  p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i && !term_i && !ev_final_beat)
      |=> (active_q && cnt_q == $past(cnt_q) + COL_W'(1)));

endmodule

// File: rtl/colgen_addr_form.sv
module colgen_addr_form #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  function automatic logic [COL_W-1:0] form_col(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] cnt,
    input logic [COL_W-1:0] mask,
    input logic             ilv
  );
    logic [COL_W-1:0] off;
    if (ilv) off = (base & mask) ^ cnt;
    else     off = ((base & mask) + cnt) & mask;
    return (base & ~mask) | (off & mask);
  endfunction

  assign col_o = form_col(base_i, cnt_i, mask_i, ilv_i);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] mask_d, mask_q, cnt_q, base_q;
  logic             page_d, ilv_d, page_q, ilv_q, active_q, last_q;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .blen_i      (blen_i),
    .ilv_i       (ilv_i),
    .wrap_mask_o (mask_d),
    .page_o      (page_d),
    .ilv_eff_o   (ilv_d)
  );

  colgen_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .term_i   (term_i),
    .col_i    (col_i),
    .mask_d   (mask_d),
    .page_d   (page_d),
    .ilv_d    (ilv_d),
    .active_o (active_q),
    .cnt_o    (cnt_q),
    .base_o   (base_q),
    .mask_o   (mask_q),
    .ilv_o    (ilv_q),
    .page_o   (page_q),
    .last_o   (last_q)
  );

  colgen_addr_form #(.COL_W(COL_W)) u_form (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign valid_o = active_q;
  assign last_o  = last_q;

  // R7: last only flags a valid beat
  p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R4: the bits above the wrap block hold while the burst runs on
  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i && !term_i && !last_o)
      |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));

  // R2: the first beat shows the captured column
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (col_o == $past(col_i)));

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int COL_W = 8;
  localparam int NV    = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0, ilv_i = 1'b0, term_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       blen_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // stimulus table: {blen code, interleave, start column}
  localparam logic [11:0] VEC [NV] = '{
    {3'd2, 1'b0, 8'h41}, {3'd2, 1'b1, 8'h41},
    {3'd1, 1'b0, 8'h13}, {3'd1, 1'b1, 8'h13},
    {3'd3, 1'b0, 8'hAD}, {3'd3, 1'b1, 8'hAD},
    {3'd0, 1'b0, 8'h77}, {3'd5, 1'b1, 8'h30},
    {3'd4, 1'b0, 8'h9C}, {3'd6, 1'b1, 8'h05}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code);
    if (code == 3'd1) return 2;
    if (code == 3'd2) return 4;
    if (code == 3'd3) return 8;
    return 1;
  endfunction

  function automatic int exp_col(input int start, input int len, input bit ilv, input int k);
    int blk = start - (start % len);
    int s   = start % len;
    if (ilv) return blk + (s ^ k);
    return blk + ((s + k) % len);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic run_fixed(input logic [11:0] v);
    int len = beats_of(v[11:9]);
    start_i = 1; blen_i = v[11:9]; ilv_i = v[8]; col_i = v[7:0];
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < len; k++) begin
      check(valid_o == 1, "R10 valid in burst", valid_o, 1);
      check(col_o == exp_col(v[7:0], len, v[8], k),
            v[8] ? "R5 interleaved column" : "R4 sequential column",
            col_o, exp_col(v[7:0], len, v[8], k));
      check(last_o == (k == len - 1), "R7 last flag", last_o, k == len - 1);
      @(negedge clk);
    end
    check(valid_o == 0, "R3 burst length ends", valid_o, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(valid_o == 0 && last_o == 0, "R1 reset idle", {valid_o, last_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(valid_o == 0, "R1 idle after reset", valid_o, 0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) run_fixed(VEC[i]);

    // R8: terminate while idle has no effect
    term_i = 1; @(negedge clk); term_i = 0;
    check(valid_o == 0, "R8 term idle", valid_o, 0);

    // R6: full page with interleave requested, wraps past top, cut by terminate
    start_i = 1; blen_i = 3'd7; ilv_i = 1; col_i = 8'hFE;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < 260; k++) begin
      check(valid_o && col_o == 8'((254 + k) % 256), "R6 page column", col_o, (254 + k) % 256);
      check(last_o == 0, "R6 page no last", last_o, 0);
      if (k == 259) term_i = 1;
      @(negedge clk);
    end
    term_i = 0;
    check(valid_o == 0, "R8 term cuts page", valid_o, 0);

    // R9: start and terminate together mid-burst, start wins
    start_i = 1; blen_i = 3'd3; ilv_i = 0; col_i = 8'h10;
    @(negedge clk); start_i = 0;
    check(col_o == 8'h10, "R2 first beat", col_o, 8'h10);
    @(negedge clk);
    check(col_o == 8'h11, "R4 second beat", col_o, 8'h11);
    start_i = 1; term_i = 1; blen_i = 3'd1; col_i = 8'h22;
    @(negedge clk); start_i = 0; term_i = 0;
    check(valid_o == 1 && col_o == 8'h22, "R9 start beats term", col_o, 8'h22);
    @(negedge clk);
    check(col_o == 8'h23 && last_o == 1, "R9 restarted burst last", col_o, 8'h23);
    @(negedge clk);
    check(valid_o == 0, "R7 idle after last", valid_o, 0);

    // R9/R10: start on last beat continues without gap
    start_i = 1; blen_i = 3'd1; col_i = 8'h05;
    @(negedge clk); start_i = 0;
    check(col_o == 8'h05, "R4 two-beat first", col_o, 8'h05);
    @(negedge clk);
    check(col_o == 8'h04 && last_o, "R4 two-beat wrap", col_o, 8'h04);
    start_i = 1; blen_i = 3'd0; col_i = 8'h60;
    @(negedge clk); start_i = 0;
    check(valid_o && col_o == 8'h60 && last_o, "R9 seamless restart", col_o, 8'h60);
    @(negedge clk);
    check(valid_o == 0, "R7 single beat ends", valid_o, 0);

    finish_run();
  end

endmodule